// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A sixteen-pin general-purpose I/O block driven through a small synchronous register bus. Each pin is set as an input or an output. Output pins carry the matching bit of an output data register, and the block reports an output enable for every pin. Input pins pass through a synchronizer. The synchronized value can be read back through a pin-control gate.

Every input pin also has its own edge selector, rising or falling. When the chosen transition appears on an unmasked input pin, the block sets a sticky status bit. One level interrupt stays high while any status bit is set. Software clears status bits by writing ones to them. Only full-width bus writes change state.

Top module: `edge_gpio_ctrl`

## Requirements
- R1: After reset the output data, direction, edge select, mask and pin-control registers read 0xFFFF, status reads 0, the input register reads 0, `irq` is 0 and every `pin_oe` bit is 0.
- R2: A direction bit of 0 makes the pin an output: `pin_oe` is 1 and `pin_out` carries the output data bit. A direction bit of 1 makes the pin an input: `pin_oe` is 0 and `pin_out` is 0.
- R3: An edge select bit of 1 latches an interrupt on a 0-to-1 input transition. A bit of 0 latches it on a 1-to-0 transition.
- R4: A status bit can only be set while its pin is an input (direction 1) and unmasked (mask 0).
- R5: A full write to the status register (offset 0x14) clears each bit written as 1 and keeps the others. `irq` is 1 exactly while any status bit is 1.
- R6: A read at offset 0x00 returns the synchronized input value ANDed bit by bit with the pin-control register (offset 0x18).
- R7: Writes to offset 0x00 change nothing. Reads of offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 return 0.
- R8: A write with `bus_full` low changes no register.
- R9: An input change reaches the 0x00 read value after two rising clock edges. It sets status on the third edge.
- R10: If a new edge event and a clearing write hit the same status bit on the same edge, the bit stays set.
- R11: A direction write changes `pin_oe` and `pin_out` right after the clock edge that takes the write, and not before that edge.
- R12: Offsets 0x04 (output data), 0x08 (direction), 0x0C (edge select), 0x10 (mask) and 0x18 (pin control) read back the last full write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_full | input | 1 | 1 marks a full 16-bit access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when `bus_rd` is low |
| pin_in | input | 16 | External pin inputs, asynchronous |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses the default parameters: 16 pins and a two-stage synchronizer. With sixteen pins, one configuration can give the low byte rising edges and the high byte falling edges. The same configuration masks the top pin and turns its neighbour into an output, so polarity, masking and direction gating show up side by side in a single status word. The two-stage depth fixes the latency that the bench checks edge by edge: two edges to the input read and three to the status bit. That same latency lets the bench line up a clearing write with a fresh edge on the same clock.

// File: rtl/egpio_pkg.sv
package egpio_pkg;
  localparam int ADDR_W = 8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DIN, SEL_DOUT, SEL_DIR, SEL_EDGE, SEL_MASK, SEL_STS, SEL_PCTL
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      8'h00:   return SEL_DIN;
      8'h04:   return SEL_DOUT;
      8'h08:   return SEL_DIR;
      8'h0C:   return SEL_EDGE;
      8'h10:   return SEL_MASK;
      8'h14:   return SEL_STS;
      8'h18:   return SEL_PCTL;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/egpio_sync.sv
module egpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb stage_d[g] = async_i;
      end else begin : g_next
        always_comb stage_d[g] = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/egpio_edge.sv
module egpio_edge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] rise_sel_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;
  logic [W-1:0] hit;

  always_comb prev_d = smp_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_pin
      always_comb begin
        if (rise_sel_i[g]) hit[g] = smp_i[g] & ~prev_q[g];
        else               hit[g] = ~smp_i[g] & prev_q[g];
      end
    end
  endgenerate

  assign evt_o = hit & dir_i & ~mask_i;
endmodule

// File: rtl/egpio_regs.sv
module egpio_regs #(
  parameter int W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [egpio_pkg::ADDR_W-1:0] addr_i,
  input  logic                         rd_i,
  input  logic                         wr_i,
  input  logic                         full_i,
  input  logic [W-1:0]                 wdata_i,
  input  logic [W-1:0]                 din_i,
  input  logic [W-1:0]                 evt_i,
  output logic [W-1:0]                 dout_q,
  output logic [W-1:0]                 dir_q,
  output logic [W-1:0]                 edge_q,
  output logic [W-1:0]                 mask_q,
  output logic [W-1:0]                 pctl_q,
  output logic [W-1:0]                 sts_q,
  output logic [W-1:0]                 rdata_o
);
  import egpio_pkg::*;

  reg_sel_e     sel;
  logic         wr_ok;
  logic [W-1:0] clr;
  logic [W-1:0] dout_d, dir_d, edge_d, mask_d, pctl_d, sts_d;

  assign sel   = decode_addr(addr_i);
  assign wr_ok = wr_i & full_i;
  assign clr   = (wr_ok && sel == SEL_STS) ? wdata_i : '0;

  always_comb begin
    dout_d = dout_q;
    dir_d  = dir_q;
    edge_d = edge_q;
    mask_d = mask_q;
    pctl_d = pctl_q;
    if (wr_ok) begin
      case (sel)
        SEL_DOUT: dout_d = wdata_i;
        SEL_DIR:  dir_d  = wdata_i;
        SEL_EDGE: edge_d = wdata_i;
        SEL_MASK: mask_d = wdata_i;
        SEL_PCTL: pctl_d = wdata_i;
        default:  ;
      endcase
    end
    sts_d = (sts_q & ~clr) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '1;
      dir_q  <= '1;
      edge_q <= '1;
      mask_q <= '1;
      pctl_q <= '1;
      sts_q  <= '0;
    end else begin
      dout_q <= dout_d;
      dir_q  <= dir_d;
      edge_q <= edge_d;
      mask_q <= mask_d;
      pctl_q <= pctl_d;
      sts_q  <= sts_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (sel)
        SEL_DIN:  rdata_o = din_i & pctl_q;
        SEL_DOUT: rdata_o = dout_q;
        SEL_DIR:  rdata_o = dir_q;
        SEL_EDGE: rdata_o = edge_q;
        SEL_MASK: rdata_o = mask_q;
        SEL_STS:  rdata_o = sts_q;
        SEL_PCTL: rdata_o = pctl_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  // Clearing write with no competing event empties the written bits.
  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && full_i && addr_i == 8'h14 && evt_i == '0)
      |=> (sts_q & $past(wdata_i)) == '0);

  // A fresh event beats a simultaneous clear.
  assert_evt_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sts_q & $past(evt_i)) == $past(evt_i));

  // A status bit only rises when an event was present.
  assert_sts_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q)) & ~$past(evt_i)) == '0);

  // Narrow writes leave configuration untouched.
  assert_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !full_i) |=> ($stable(dout_q) && $stable(dir_q) && $stable(edge_q)
                           && $stable(mask_q) && $stable(pctl_q)));
endmodule

// File: rtl/edge_gpio_ctrl.sv
module edge_gpio_ctrl #(
  parameter int NPINS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [egpio_pkg::ADDR_W-1:0] bus_addr,
  input  logic                         bus_rd,
  input  logic                         bus_wr,
  input  logic                         bus_full,
  input  logic [NPINS-1:0]             bus_wdata,
  output logic [NPINS-1:0]             bus_rdata,
  input  logic [NPINS-1:0]             pin_in,
  output logic [NPINS-1:0]             pin_out,
  output logic [NPINS-1:0]             pin_oe,
  output logic                         irq
);
  logic [NPINS-1:0] smp, evt;
  logic [NPINS-1:0] dout_q, dir_q, edge_q, mask_q, pctl_q, sts_q;

  egpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(smp)
  );

  egpio_edge #(.W(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .smp_i(smp), .rise_sel_i(edge_q),
    .dir_i(dir_q), .mask_i(mask_q), .evt_o(evt)
  );

  egpio_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .rd_i(bus_rd),
    .wr_i(bus_wr), .full_i(bus_full), .wdata_i(bus_wdata), .din_i(smp),
    .evt_i(evt), .dout_q(dout_q), .dir_q(dir_q), .edge_q(edge_q),
    .mask_q(mask_q), .pctl_q(pctl_q), .sts_q(sts_q), .rdata_o(bus_rdata)
  );

  assign pin_oe  = ~dir_q;
  assign pin_out = dout_q & ~dir_q;
  assign irq     = |sts_q;

  // Events never come from output or masked pins.
  assert_evt_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & (~dir_q | mask_q)) == '0);

  // Direction write shows on the enables after its edge.
  assert_dir_oe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_full && bus_addr == 8'h08) |=> pin_oe == ~$past(bus_wdata));

  // The interrupt drops once status is fully cleared with no new event.
  assert_irq_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_full && bus_addr == 8'h14 && (sts_q & ~bus_wdata) == '0
     && evt == '0) |=> !irq);
endmodule

// File: tb/sim_edge_gpio_ctrl.sv
`timescale 1ns/1ps
module sim_edge_gpio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_rd, bus_wr, bus_full;
  logic [15:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
  logic        irq;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  edge_gpio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_full(bus_full), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  // {is_write, offset, write data, expected read}
  localparam int NV = 17;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h04, 16'hA5A5, 16'h0000}, {1'b0, 8'h04, 16'h0000, 16'hA5A5},
    {1'b1, 8'h08, 16'h0F0F, 16'h0000}, {1'b0, 8'h08, 16'h0000, 16'h0F0F},
    {1'b1, 8'h0C, 16'h00FF, 16'h0000}, {1'b0, 8'h0C, 16'h0000, 16'h00FF},
    {1'b1, 8'h10, 16'h1234, 16'h0000}, {1'b0, 8'h10, 16'h0000, 16'h1234},
    {1'b1, 8'h18, 16'hFF00, 16'h0000}, {1'b0, 8'h18, 16'h0000, 16'hFF00},
    {1'b1, 8'h00, 16'h5555, 16'h0000}, {1'b0, 8'h00, 16'h0000, 16'hFF00},
    {1'b0, 8'h04, 16'h0000, 16'hA5A5}, {1'b0, 8'h14, 16'h0000, 16'h0000},
    {1'b0, 8'h1C, 16'h0000, 16'h0000}, {1'b0, 8'h40, 16'h0000, 16'h0000},
    {1'b0, 8'h12, 16'h0000, 16'h0000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d, input logic full);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_full = full; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_full = 1'b1;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [15:0] r;
    rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_full = 1'b1; bus_wdata = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(8'h04, r); check("R1 dout", r, 16'hFFFF);
    bus_read(8'h08, r); check("R1 dir", r, 16'hFFFF);
    bus_read(8'h0C, r); check("R1 edge", r, 16'hFFFF);
    bus_read(8'h10, r); check("R1 mask", r, 16'hFFFF);
    bus_read(8'h18, r); check("R1 pctl", r, 16'hFFFF);
    bus_read(8'h14, r); check("R1 status", r, 16'h0000);
    bus_read(8'h00, r); check("R1 input", r, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0000);
    check("R1 pin_oe", pin_oe, 16'h0000);

    pin_in = 16'hFFFF;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // Table walk: R12 readback, R6 gated input, R7 ignored write and unmapped reads
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) bus_write(VEC[i][39:32], VEC[i][31:16], 1'b1);
      else begin
        bus_read(VEC[i][39:32], r);
        check($sformatf("R12 R6 R7 table entry %0d", i), r, VEC[i][15:0]);
      end
    end

    // R2 pin drive
    check("R2 pin_out", pin_out, 16'hA0A0);
    check("R2 pin_oe", pin_oe, 16'hF0F0);

    // R8 narrow write ignored
    bus_write(8'h04, 16'h0000, 1'b0);
    bus_read(8'h04, r); check("R8 dout after narrow write", r, 16'hA5A5);
    check("R8 pin_out after narrow write", pin_out, 16'hA0A0);

    // R11 direction timing
    @(negedge clk);
    bus_addr = 8'h08; bus_wdata = 16'h0000; bus_full = 1'b1; bus_wr = 1'b1;
    #1 check("R11 oe before edge", pin_oe, 16'hF0F0);
    @(posedge clk); #1;
    check("R11 oe after edge", pin_oe, 16'hFFFF);
    check("R11 pin_out after edge", pin_out, 16'hA5A5);
    @(negedge clk); bus_wr = 1'b0;

    // Edge setup: low byte rising, high byte falling, pin 15 masked, pin 14 output
    bus_write(8'h10, 16'hFFFF, 1'b1);
    bus_write(8'h08, 16'hFFFF, 1'b1);
    bus_write(8'h18, 16'hFFFF, 1'b1);
    pin_in = 16'h0000;
    repeat (4) @(posedge clk);
    bus_write(8'h14, 16'hFFFF, 1'b1);
    bus_write(8'h0C, 16'h00FF, 1'b1);
    bus_write(8'h10, 16'h8000, 1'b1);
    bus_write(8'h08, 16'hBFFF, 1'b1);

    // Rising transition on every pin, with R9 latency
    pin_in = 16'hFFFF;
    @(posedge clk); @(negedge clk);
    bus_read(8'h00, r); check("R9 input after one edge", r, 16'h0000);
    @(posedge clk); @(negedge clk);
    bus_read(8'h00, r); check("R9 input after two edges", r, 16'hFFFF);
    check("R9 irq after two edges", {15'b0, irq}, 16'h0000);
    @(posedge clk); @(negedge clk);
    bus_read(8'h14, r); check("R3 R4 rising status", r, 16'h00FF);
    check("R5 irq set", {15'b0, irq}, 16'h0001);

    // R5 partial and full clear
    bus_write(8'h14, 16'h000F, 1'b1);
    bus_read(8'h14, r); check("R5 partial clear", r, 16'h00F0);
    check("R5 irq held", {15'b0, irq}, 16'h0001);
    bus_write(8'h14, 16'h00F0, 1'b1);
    bus_read(8'h14, r); check("R5 full clear", r, 16'h0000);
    check("R5 irq low", {15'b0, irq}, 16'h0000);

    // Falling transition on every pin
    pin_in = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    bus_read(8'h14, r); check("R3 R4 falling status", r, 16'h3F00);
    bus_write(8'h14, 16'hFFFF, 1'b1);
    bus_read(8'h14, r); check("R5 clear all", r, 16'h0000);

    // R10 event and clear on the same edge
    pin_in = 16'h0001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    bus_read(8'h14, r); check("R10 setup bit set", r, 16'h0001);
    pin_in = 16'h0000;
    repeat (4) @(posedge clk);
    @(negedge clk);
    pin_in = 16'h0001;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_addr = 8'h14; bus_wdata = 16'h0001; bus_full = 1'b1; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b0;
    bus_read(8'h14, r); check("R10 event wins over clear", r, 16'h0001);
    check("R10 irq held", {15'b0, irq}, 16'h0001);
    bus_write(8'h14, 16'h0001, 1'b1);
    bus_read(8'h14, r); check("R5 clear after collision", r, 16'h0000);

    done = 1'b1;
    summary();
  end
endmodule